// File: doc/BRIEF.md
# Register stack frame renamer

The renamer turns a logical general-register number into an index into a windowed physical register file. Numbers 0 to 31 form a static set and pass straight through. Numbers from 32 upward are taken relative to the base of the current procedure frame, so every procedure sees its own frame starting at logical 32. The stacked storage holds 96 entries, and frame bases wrap around inside it. The mapping is combinational. The current frame state changes only on the clock edge, when a call, return or alloc command arrives.

Each frame has a local area followed by an output area. A call does not open a fresh, empty window. The callee frame begins with zero locals and lies exactly over the caller's output registers, so arguments need no copying. The caller's frame description goes onto a small marker stack, and a return restores it from there. An alloc command resizes the current frame. When the legacy-mode input is high, renaming is switched off and every number maps to itself.

Top module: `rsf_renamer`

## Requirements
- R1: With legacy mode off, a logical number 0..31 gives a physical index equal to that number and never raises `illegal_o`, whatever the frame state.
- R2: A logical number r of 32 or more gives physical index 32 + ((base + r - 32) mod 96). After reset the base is 0.
- R3: An alloc with frame size at most 96 and local size at most the frame size sets both sizes of the current frame, seen at the ports from the cycle after the strobe edge. The base is kept.
- R4: An alloc with frame size above 96, or with local size above frame size, pulses `alloc_err_o` and leaves the frame unchanged.
- R5: With legacy mode off, `illegal_o` is high exactly for logical numbers at or beyond 32 plus the current frame size. Reset sets the frame size to 0.
- R6: An accepted call advances the base by the old local size (mod 96), sets the frame size to the old frame size minus the old local size, and sets the local size to 0.
- R7: An accepted return restores the base, local size and frame size that held before the matching call.
- R8: A return while no frames are saved pulses `underflow_o` and leaves the state unchanged.
- R9: A call while 8 frames are already saved pulses `overflow_o` and leaves the state unchanged.
- R10: While legacy mode is high, every logical number maps to itself, `illegal_o` is low, and call, return and alloc strobes have no effect and raise no flag.
- R11: Only one command acts per cycle. The priority is call, then return, then alloc.
- R12: The three flags are registered. Each is high for exactly the one cycle after the offending edge and low otherwise, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_i | input | 1 | Disables renaming and commands |
| lreg_i | input | 7 | Logical register number |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| alloc_i | input | 1 | Alloc strobe |
| alloc_local_i | input | 7 | Local-area size for alloc |
| alloc_frame_i | input | 7 | Frame size for alloc |
| preg_o | output | 7 | Physical register index |
| illegal_o | output | 1 | Access outside the current frame |
| overflow_o | output | 1 | Call with the marker stack full |
| underflow_o | output | 1 | Return with the marker stack empty |
| alloc_err_o | output | 1 | Alloc with invalid sizes |

## Verification
A wrong base shows up at once on `preg_o` for every stacked number, in the first cycle after the faulty command. A wrong frame size moves the `illegal_o` boundary in that same cycle. Damage to a saved marker stays hidden until the matching return; the bench therefore checks the mapping and the boundary after every return, including the returns after an eight-deep chain of calls. A wrong stack count shows as an overflow or underflow flag that is missing or extra, one cycle after the ninth call or the first return on an empty stack.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int unsigned STATIC_REGS = 32;
  localparam int unsigned STACK_REGS  = 96;
  localparam int unsigned LREG_W      = $clog2(STATIC_REGS + STACK_REGS);
  localparam int unsigned SIZE_W      = $clog2(STACK_REGS + 1);
  localparam int unsigned BASE_W      = $clog2(STACK_REGS);

  typedef logic [LREG_W-1:0] lreg_t;
  typedef logic [SIZE_W-1:0] size_t;
  typedef logic [BASE_W-1:0] base_t;

  typedef struct packed {
    base_t base;
    size_t sol;   // local-area size
    size_t sof;   // whole frame size
  } frame_t;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_CALL,
    CMD_RET,
    CMD_ALLOC
  } cmd_e;
endpackage

// File: rtl/rsf_cmd_decode.sv
module rsf_cmd_decode
  import rsf_pkg::*;
(
  input  logic legacy_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic alloc_i,
  output cmd_e cmd_o
);
  // one command per cycle: call > ret > alloc
  always_comb begin
    if (legacy_i)     cmd_o = CMD_NONE;
    else if (call_i)  cmd_o = CMD_CALL;
    else if (ret_i)   cmd_o = CMD_RET;
    else if (alloc_i) cmd_o = CMD_ALLOC;
    else              cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/rsf_marker_stack.sv
module rsf_marker_stack
  import rsf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  frame_t           push_data_i,
  output frame_t           top_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  frame_t           mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_idx  = IDX_W'(cnt_q);
  assign rd_idx  = IDX_W'(cnt_q - CNT_W'(1));
  assign full_o  = (cnt_q == DEPTH_C);
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign top_o   = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[wr_idx] <= push_data_i;
      cnt_q         <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rsf_frame_ctrl.sv
module rsf_frame_ctrl
  import rsf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cmd_e   cmd_i,
  input  size_t  alloc_local_i,
  input  size_t  alloc_frame_i,
  input  frame_t saved_i,
  input  logic   stk_full_i,
  input  logic   stk_empty_i,
  output frame_t frame_o,
  output logic   push_o,
  output logic   pop_o,
  output logic   overflow_o,
  output logic   underflow_o,
  output logic   alloc_err_o
);
  localparam logic [BASE_W:0] STACK_C = (BASE_W+1)'(STACK_REGS);
  localparam size_t           MAXF_C  = SIZE_W'(STACK_REGS);

  frame_t          cur_q, cur_d;
  logic            ovf_d, unf_d, err_d;
  logic [BASE_W:0] base_sum;
  base_t           callee_base;

  // callee base = base + locals, wrapped inside the stacked storage
  assign base_sum    = {1'b0, cur_q.base} + (BASE_W+1)'(cur_q.sol);
  assign callee_base = (base_sum >= STACK_C) ? BASE_W'(base_sum - STACK_C)
                                             : BASE_W'(base_sum);

  always_comb begin
    cur_d  = cur_q;
    push_o = 1'b0;
    pop_o  = 1'b0;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    err_d  = 1'b0;
    unique case (cmd_i)
      CMD_CALL: begin
        if (stk_full_i) ovf_d = 1'b1;
        else begin
          push_o     = 1'b1;
          cur_d.base = callee_base;
          cur_d.sof  = cur_q.sof - cur_q.sol;
          cur_d.sol  = '0;
        end
      end
      CMD_RET: begin
        if (stk_empty_i) unf_d = 1'b1;
        else begin
          pop_o = 1'b1;
          cur_d = saved_i;
        end
      end
      CMD_ALLOC: begin
        if (alloc_frame_i > MAXF_C || alloc_local_i > alloc_frame_i) err_d = 1'b1;
        else begin
          cur_d.sol = alloc_local_i;
          cur_d.sof = alloc_frame_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      alloc_err_o <= 1'b0;
    end else begin
      cur_q       <= cur_d;
      overflow_o  <= ovf_d;
      underflow_o <= unf_d;
      alloc_err_o <= err_d;
    end
  end

  assign frame_o = cur_q;
endmodule

// File: rtl/rsf_map.sv
module rsf_map
  import rsf_pkg::*;
(
  input  logic   legacy_i,
  input  lreg_t  lreg_i,
  input  frame_t frame_i,
  output lreg_t  preg_o,
  output logic   illegal_o
);
  localparam lreg_t           STATIC_C = LREG_W'(STATIC_REGS);
  localparam logic [LREG_W:0] STACK_C  = (LREG_W+1)'(STACK_REGS);

  logic            stacked;
  lreg_t           rel;
  logic [LREG_W:0] off_sum;
  lreg_t           off;

  assign stacked = (lreg_i >= STATIC_C);
  assign rel     = lreg_i - STATIC_C;
  assign off_sum = (LREG_W+1)'(frame_i.base) + {1'b0, rel};
  assign off     = (off_sum >= STACK_C) ? LREG_W'(off_sum - STACK_C) : LREG_W'(off_sum);

  always_comb begin
    if (legacy_i || !stacked) begin
      preg_o    = lreg_i;
      illegal_o = 1'b0;
    end else begin
      preg_o    = STATIC_C + off;
      illegal_o = (rel >= LREG_W'(frame_i.sof));
    end
  end
endmodule

// File: rtl/rsf_renamer.sv
module rsf_renamer
  import rsf_pkg::*;
#(
  parameter int unsigned MARKER_DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(MARKER_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              legacy_i,
  input  logic [LREG_W-1:0] lreg_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              alloc_i,
  input  logic [SIZE_W-1:0] alloc_local_i,
  input  logic [SIZE_W-1:0] alloc_frame_i,
  output logic [LREG_W-1:0] preg_o,
  output logic              illegal_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              alloc_err_o
);
  cmd_e             cmd;
  frame_t           cur_frame, saved_frame;
  logic             push, pop, stk_full, stk_empty;
  logic [CNT_W-1:0] depth;

  rsf_cmd_decode i_decode (
    .legacy_i (legacy_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .alloc_i  (alloc_i),
    .cmd_o    (cmd)
  );

  rsf_frame_ctrl i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .alloc_local_i (alloc_local_i),
    .alloc_frame_i (alloc_frame_i),
    .saved_i       (saved_frame),
    .stk_full_i    (stk_full),
    .stk_empty_i   (stk_empty),
    .frame_o       (cur_frame),
    .push_o        (push),
    .pop_o         (pop),
    .overflow_o    (overflow_o),
    .underflow_o   (underflow_o),
    .alloc_err_o   (alloc_err_o)
  );

  rsf_marker_stack #(.DEPTH(MARKER_DEPTH)) i_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (cur_frame),
    .top_o       (saved_frame),
    .full_o      (stk_full),
    .empty_o     (stk_empty),
    .count_o     (depth)
  );

  rsf_map i_map (
    .legacy_i  (legacy_i),
    .lreg_i    (lreg_i),
    .frame_i   (cur_frame),
    .preg_o    (preg_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/rsf_renamer_chk.sv
module rsf_renamer_chk
  import rsf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              legacy_i,
  input logic [LREG_W-1:0] lreg_i,
  input logic              call_i,
  input logic              ret_i,
  input logic [LREG_W-1:0] preg_o,
  input logic              illegal_o,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic              alloc_err_o,
  input frame_t            frame_i,
  input logic [CNT_W-1:0]  depth_i
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam size_t            MAXF_C  = SIZE_W'(STACK_REGS);

  assert_static_identity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lreg_i < LREG_W'(STATIC_REGS)) |-> (preg_o == lreg_i && !illegal_o));

  assert_frame_bounds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i.sof <= MAXF_C) && (frame_i.sol <= frame_i.sof));

  assert_call_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !legacy_i && depth_i != DEPTH_C) |=>
      (depth_i == $past(depth_i) + CNT_W'(1) && frame_i.sol == '0 &&
       frame_i.sof == $past(frame_i.sof) - $past(frame_i.sol)));

  assert_ret_pops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !legacy_i && depth_i != '0) |=>
      (depth_i == $past(depth_i) - CNT_W'(1)));

  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> ($past(depth_i) == '0 && $past(ret_i) && $stable(frame_i)));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(depth_i) == DEPTH_C && $past(call_i) && $stable(frame_i)));

  assert_legacy_map_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |-> (preg_o == lreg_i && !illegal_o));

  assert_legacy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |=> ($stable(frame_i) && $stable(depth_i) &&
                  !overflow_o && !underflow_o && !alloc_err_o));

  assert_flags_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({overflow_o, underflow_o, alloc_err_o}));
endmodule

bind rsf_renamer rsf_renamer_chk #(.DEPTH(MARKER_DEPTH)) i_rsf_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .legacy_i    (legacy_i),
  .lreg_i      (lreg_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .preg_o      (preg_o),
  .illegal_o   (illegal_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .alloc_err_o (alloc_err_o),
  .frame_i     (cur_frame),
  .depth_i     (depth)
);

// File: tb/test_rsf_renamer.sv
`timescale 1ns/1ps
module test_rsf_renamer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       legacy_i = 1'b0;
  logic [6:0] lreg_i = '0;
  logic       call_i = 1'b0, ret_i = 1'b0, alloc_i = 1'b0;
  logic [6:0] alloc_local_i = '0, alloc_frame_i = '0;
  logic [6:0] preg_o;
  logic       illegal_o, overflow_o, underflow_o, alloc_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rsf_renamer i_rsf_renamer (
    .clk_i, .rst_ni, .legacy_i, .lreg_i, .call_i, .ret_i, .alloc_i,
    .alloc_local_i, .alloc_frame_i, .preg_o, .illegal_o,
    .overflow_o, .underflow_o, .alloc_err_o
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    legacy_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // exp_preg < 0 means the index is not checked
  task automatic map(string req, int lreg, int exp_preg, bit exp_ill);
    @(negedge clk_i);
    lreg_i = 7'(lreg);
    #1;
    if (exp_preg >= 0) check({req, " preg"}, int'(preg_o), exp_preg);
    check({req, " illegal"}, int'(illegal_o), int'(exp_ill));
  endtask

  task automatic cmd(string req, bit c, bit r, bit a, int loc, int frm,
                     bit e_ovf, bit e_unf, bit e_err);
    @(negedge clk_i);
    call_i = c; ret_i = r; alloc_i = a;
    alloc_local_i = 7'(loc); alloc_frame_i = 7'(frm);
    @(negedge clk_i);
    call_i = 1'b0; ret_i = 1'b0; alloc_i = 1'b0;
    #1;
    check({req, " overflow"},  int'(overflow_o),  int'(e_ovf));
    check({req, " underflow"}, int'(underflow_o), int'(e_unf));
    check({req, " alloc_err"}, int'(alloc_err_o), int'(e_err));
    @(negedge clk_i);
    #1;
    check({req, " flag cleared"}, int'(overflow_o | underflow_o | alloc_err_o), 0);
  endtask

  task automatic t_reset();
    map("R1 reset static", 5, 5, 0);
    map("R5 reset empty frame", 40, -1, 1);
    map("R5 reset lreg32", 32, -1, 1);
    check("R12 reset flags", int'(overflow_o | underflow_o | alloc_err_o), 0);
  endtask

  task automatic t_alloc();
    cmd("R3 alloc 4/10", 0, 0, 1, 4, 10, 0, 0, 0);
    map("R2 lreg32", 32, 32, 0);
    map("R5 last legal", 41, 41, 0);
    map("R5 first illegal", 42, -1, 1);
    map("R1 static 31", 31, 31, 0);
  endtask

  task automatic t_bad_alloc();
    cmd("R4 frame 97", 0, 0, 1, 4, 97, 0, 0, 1);
    map("R4 kept legal", 41, 41, 0);
    map("R4 kept illegal", 42, -1, 1);
    cmd("R4 local>frame", 0, 0, 1, 11, 10, 0, 0, 1);
    map("R4 kept legal2", 41, 41, 0);
    map("R4 kept illegal2", 42, -1, 1);
  endtask

  task automatic t_call_ret();
    cmd("R6 call", 1, 0, 0, 0, 0, 0, 0, 0);
    map("R6 callee lreg32", 32, 36, 0);
    map("R6 callee top", 37, 41, 0);
    map("R6 callee illegal", 38, -1, 1);
    cmd("R3 callee alloc", 0, 0, 1, 2, 8, 0, 0, 0);
    map("R3 callee lreg39", 39, 43, 0);
    map("R3 callee illegal", 40, -1, 1);
    cmd("R7 ret", 0, 1, 0, 0, 0, 0, 0, 0);
    map("R7 restored legal", 41, 41, 0);
    map("R7 restored illegal", 42, -1, 1);
    map("R7 restored base", 33, 33, 0);
  endtask

  task automatic t_wrap();
    cmd("R3 alloc 90/96", 0, 0, 1, 90, 96, 0, 0, 0);
    map("R5 full frame top", 127, 127, 0);
    cmd("R6 call wrap", 1, 0, 0, 0, 0, 0, 0, 0);
    map("R2 base90", 32, 122, 0);
    map("R2 base90 end", 37, 127, 0);
    cmd("R3 alloc 0/20", 0, 0, 1, 0, 20, 0, 0, 0);
    map("R2 wraps", 42, 36, 0);
    map("R2 wraps end", 51, 45, 0);
    cmd("R7 ret wrap", 0, 1, 0, 0, 0, 0, 0, 0);
    map("R7 ret base0", 40, 40, 0);
  endtask

  task automatic t_depth();
    do_reset();
    cmd("R8 ret empty", 0, 1, 0, 0, 0, 0, 1, 0);
    map("R8 state kept", 32, -1, 1);
    cmd("R3 alloc 1/2", 0, 0, 1, 1, 2, 0, 0, 0);
    for (int i = 0; i < 8; i++) cmd("R6 chain call", 1, 0, 0, 0, 0, 0, 0, 0);
    map("R6 chain base", 32, 33, 0);
    cmd("R9 ninth call", 1, 0, 0, 0, 0, 1, 0, 0);
    map("R9 kept base", 32, 33, 0);
    map("R9 kept size", 33, -1, 1);
    for (int i = 0; i < 8; i++) cmd("R7 chain ret", 0, 1, 0, 0, 0, 0, 0, 0);
    map("R7 chain restored", 33, 33, 0);
    map("R7 chain restored illegal", 34, -1, 1);
    cmd("R8 ret after chain", 0, 1, 0, 0, 0, 0, 1, 0);
    map("R8 kept after chain", 33, 33, 0);
  endtask

  task automatic t_legacy();
    do_reset();
    cmd("R3 alloc 3/5", 0, 0, 1, 3, 5, 0, 0, 0);
    @(negedge clk_i);
    legacy_i = 1'b1;
    map("R10 identity", 100, 100, 0);
    map("R10 identity low", 36, 36, 0);
    cmd("R10 call ignored", 1, 0, 0, 0, 0, 0, 0, 0);
    cmd("R10 ret ignored", 0, 1, 0, 0, 0, 0, 0, 0);
    cmd("R10 alloc ignored", 0, 0, 1, 0, 1, 0, 0, 0);
    cmd("R10 bad alloc ignored", 0, 0, 1, 9, 3, 0, 0, 0);
    @(negedge clk_i);
    legacy_i = 1'b0;
    map("R10 frame kept", 36, 36, 0);
    map("R10 frame kept illegal", 37, -1, 1);
  endtask

  task automatic t_priority();
    do_reset();
    cmd("R3 alloc 2/6", 0, 0, 1, 2, 6, 0, 0, 0);
    cmd("R11 call+ret+alloc", 1, 1, 1, 0, 0, 0, 0, 0);
    map("R11 call won", 32, 34, 0);
    map("R11 call won top", 35, 37, 0);
    map("R11 call won illegal", 36, -1, 1);
    cmd("R11 ret+bad alloc", 0, 1, 1, 9, 3, 0, 0, 0);
    map("R11 ret won", 37, 37, 0);
    map("R11 ret won illegal", 38, -1, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_alloc();
    t_bad_alloc();
    t_call_ret();
    t_wrap();
    t_depth();
    t_legacy();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule